// File: doc/BRIEF.md
# Dual Trigger Unit

This block watches a 32-bit sample stream and raises a one-cycle trigger pulse once a programmed condition is met. A sample is taken in every cycle in which the valid input is high. Two identical trigger units evaluate each sample. Each unit is programmed by a 32-bit flags word and seven 32-bit parameters:

- a lower and upper bus bound,
- a lower and upper duration bound,
- a bus mask,
- a pattern mask,
- a pattern value.

A unit can look for several things:

- a transition on one chosen channel;
- a masked bus value that falls into one of four window relations;
- the length of a run of samples that satisfy the bus window;
- a pattern match on the sample before, at, or after the sample that met the other conditions.

Masked bits are packed downward into a contiguous value before any comparison. The outputs of the enabled units are merged with a logical AND or OR.

Software arms the block with a single-cycle pulse. The arm pulse also wipes the sample history: the previous sample, the run counter and the pending next-sample decision. The block then fires at most once, on the first qualifying sample, and stays silent until it is armed again. Configuration inputs are expected to stay stable while the block is armed.

Top module: `dual_trigger`

## Requirements
- R1: After reset `trig_o` is low and the block is disarmed, so samples presented before the first arm pulse never produce a trigger.
- R2: `arm_i` arms the block and clears all unit history. A sample presented in the same cycle as `arm_i` is ignored. A qualifying sample makes `trig_o` high for exactly the next cycle, and no further trigger follows until the block is armed again.
- R3: Flags bits 4:0 choose the channel for the edge term, and flags bits 6:5 choose the edge: 00 rising, 01 falling, 10 either, 11 edge term off. The first sample after arming has no predecessor and never counts as an edge.
- R4: Before comparison, the sample bits selected by a mask are packed into bit 0 upward, in ascending bit order, and the upper bits are filled with zeros.
- R5: Flags bit 12 enables the bus window term, and flags bits 9:8 pick its relation between the packed value v and the bounds lo and hi. The relations are: 00 v==hi, 01 v==lo or v==hi, 10 v<lo or v>hi, 11 lo<v<hi.
- R6: Flags bit 13 enables the duration term. This term counts consecutive samples that meet the bus window relation. It is judged on the first sample that breaks a run of length n≥1, comparing n with the duration bounds under the relation in flags bits 11:10, which uses the same codes as R5. While the duration term is enabled, bit 12 does not gate the unit.
- R7: The run counter saturates at 2^RUN_W-1 instead of wrapping.
- R8: Flags bit 18 enables the pattern term: the sample packed through the pattern mask must equal the pattern value. Flags bits 17:16 set where the pattern is checked: 00 on the sample after the one meeting the other terms, 01 on the same sample, 10 on the sample before it, 11 never.
- R9: A unit fires only when all of its enabled terms hold together. A unit with no term enabled fires on the first sample after arming.
- R10: `unit_en_i[i]` enables unit i, and `both_req_i` chooses AND (1) or OR (0) over the enabled units. A disabled unit takes no part, and with no unit enabled the block fires on the first sample after arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm pulse, also clears unit history |
| smp_vld_i | input | 1 | Sample valid |
| smp_i | input | 32 | Sample data, one bit per channel |
| unit_en_i | input | 2 | Per-unit enable |
| both_req_i | input | 1 | 1: AND of enabled units, 0: OR |
| u_flags_i | input | 2x32 | Per-unit flags word |
| u_rng_lo_i | input | 2x32 | Per-unit lower bus bound |
| u_rng_hi_i | input | 2x32 | Per-unit upper bus bound |
| u_tm_lo_i | input | 2x32 | Per-unit lower duration bound |
| u_tm_hi_i | input | 2x32 | Per-unit upper duration bound |
| u_rng_mask_i | input | 2x32 | Per-unit bus mask |
| u_pat_mask_i | input | 2x32 | Per-unit pattern mask |
| u_pat_val_i | input | 2x32 | Per-unit packed pattern value |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The two functions that can coincide are the edge hits of the two units. In AND mode they must land on the same sample, while OR mode takes whichever arrives first. The bench provokes this with a sequence in which channel 0 rises alone first, and later channels 0 and 1 rise on the same sample. It sweeps every enable and combine setting over that sequence and predicts, for each setting, the exact sample index that fires. A second coincidence is an arm pulse that meets a valid sample in the same cycle. The bench judges it by requiring silence on that cycle and a trigger on the next sample.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;
    localparam int SMP_W   = 32;
    localparam int CH_W    = $clog2(SMP_W);
    localparam int N_UNITS = 2;

    typedef enum logic [1:0] {
        WIN_EQ_HI  = 2'b00,
        WIN_EQ_ANY = 2'b01,
        WIN_OUT    = 2'b10,
        WIN_IN     = 2'b11
    } win_mode_e;

    typedef enum logic [1:0] {
        EDG_RISE = 2'b00,
        EDG_FALL = 2'b01,
        EDG_ANY  = 2'b10,
        EDG_OFF  = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        PAT_NEXT = 2'b00,
        PAT_CUR  = 2'b01,
        PAT_PREV = 2'b10,
        PAT_NONE = 2'b11
    } pat_pos_e;

    // Field positions are decoded by configuration software.
    typedef struct packed {
        logic [12:0]   rsv_hi;
        logic          pat_en;
        pat_pos_e      pat_pos;
        logic [1:0]    rsv_mid;
        logic          dur_en;
        logic          win_en;
        win_mode_e     dur_mode;
        win_mode_e     win_mode;
        logic          rsv_lo;
        edge_sel_e     edge_sel;
        logic [CH_W-1:0] chan;
    } unit_flags_t;

    typedef struct packed {
        logic [SMP_W-1:0] rng_lo;
        logic [SMP_W-1:0] rng_hi;
        logic [SMP_W-1:0] tm_lo;
        logic [SMP_W-1:0] tm_hi;
        logic [SMP_W-1:0] rng_mask;
        logic [SMP_W-1:0] pat_mask;
        logic [SMP_W-1:0] pat_val;
    } unit_par_t;

    function automatic logic window_hit(input win_mode_e m,
                                        input logic [SMP_W-1:0] v,
                                        input logic [SMP_W-1:0] lo,
                                        input logic [SMP_W-1:0] hi);
        logic r;
        case (m)
            WIN_EQ_HI:  r = (v == hi);
            WIN_EQ_ANY: r = (v == lo) || (v == hi);
            WIN_OUT:    r = (v < lo) || (v > hi);
            default:    r = (v > lo) && (v < hi);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/bit_compactor.sv
`timescale 1ns/1ps
module bit_compactor #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] pack_o
);
    localparam int RW = $clog2(W);

    // rank[i]: number of selected bits below bit i
    logic [RW-1:0] rank [W];

    assign rank[0] = '0;
    for (genvar i = 1; i < W; i++) begin : g_rank
        assign rank[i] = rank[i-1] + RW'(mask_i[i-1]);
    end

    always_comb begin
        pack_o = '0;
        for (int i = 0; i < W; i++) begin
            if (mask_i[i]) pack_o[rank[i]] = val_i[i];
        end
    end
endmodule

// File: rtl/run_length_counter.sv
`timescale 1ns/1ps
module run_length_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          adv_i,
    input  logic          hold_i,
    output logic [CW-1:0] len_o,
    output logic          done_o
);
    localparam logic [CW-1:0] LEN_MAX = '1;

    logic [CW-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            len_q <= '0;
        end else if (adv_i) begin
            if (!hold_i)                len_q <= '0;
            else if (len_q != LEN_MAX)  len_q <= len_q + 1'b1;
        end
    end

    assign len_o  = len_q;
    assign done_o = adv_i && !hold_i && (len_q != '0);
endmodule

// File: rtl/trig_unit.sv
`timescale 1ns/1ps
module trig_unit
    import trig_pkg::*;
#(
    parameter int RUN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [SMP_W-1:0] smp_i,
    input  unit_flags_t      flags_i,
    input  unit_par_t        par_i,
    output logic             hit_o
);
    logic [SMP_W-1:0] prev_q;
    logic             have_prev_q;
    logic             prev_pat_q;
    logic             pend_q;

    logic [SMP_W-1:0] win_val, pat_pack;
    logic             win_ok, pat_ok;
    logic [RUN_W-1:0] run_len;
    logic             run_done, dur_ok;
    logic             cur_b, prv_b, edge_ok;
    logic             edge_on, win_on, dur_on, any_term, others;

    logic unused_flag_bits;
    assign unused_flag_bits = ^{flags_i.rsv_hi, flags_i.rsv_mid, flags_i.rsv_lo};

    bit_compactor #(.W(SMP_W)) u_win_pack (
        .val_i (smp_i),
        .mask_i(par_i.rng_mask),
        .pack_o(win_val)
    );

    bit_compactor #(.W(SMP_W)) u_pat_pack (
        .val_i (smp_i),
        .mask_i(par_i.pat_mask),
        .pack_o(pat_pack)
    );

    assign win_ok = window_hit(flags_i.win_mode, win_val, par_i.rng_lo, par_i.rng_hi);
    assign pat_ok = (pat_pack == par_i.pat_val);

    run_length_counter #(.CW(RUN_W)) u_run (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_i),
        .adv_i (adv_i),
        .hold_i(win_ok),
        .len_o (run_len),
        .done_o(run_done)
    );

    assign dur_ok = run_done &&
                    window_hit(flags_i.dur_mode, SMP_W'(run_len), par_i.tm_lo, par_i.tm_hi);

    assign cur_b = smp_i[flags_i.chan];
    assign prv_b = prev_q[flags_i.chan];

    always_comb begin
        case (flags_i.edge_sel)
            EDG_RISE: edge_ok = have_prev_q && !prv_b && cur_b;
            EDG_FALL: edge_ok = have_prev_q && prv_b && !cur_b;
            EDG_ANY:  edge_ok = have_prev_q && (prv_b != cur_b);
            default:  edge_ok = 1'b0;
        endcase
    end

    assign edge_on  = (flags_i.edge_sel != EDG_OFF);
    assign dur_on   = flags_i.dur_en;
    assign win_on   = flags_i.win_en && !flags_i.dur_en;
    assign any_term = edge_on || win_on || dur_on || flags_i.pat_en;
    assign others   = (!edge_on || edge_ok) && (!win_on || win_ok) && (!dur_on || dur_ok);

    always_comb begin
        if (flags_i.pat_en) begin
            case (flags_i.pat_pos)
                PAT_NEXT: hit_o = pend_q && pat_ok;
                PAT_CUR:  hit_o = others && pat_ok;
                PAT_PREV: hit_o = others && have_prev_q && prev_pat_q;
                default:  hit_o = 1'b0;
            endcase
        end else begin
            hit_o = any_term ? others : 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            prev_pat_q  <= 1'b0;
            pend_q      <= 1'b0;
        end else if (adv_i) begin
            prev_q      <= smp_i;
            have_prev_q <= 1'b1;
            prev_pat_q  <= pat_ok;
            pend_q      <= others;
        end
    end
endmodule

// File: rtl/dual_trigger.sv
`timescale 1ns/1ps
module dual_trigger
    import trig_pkg::*;
#(
    parameter int RUN_W = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           arm_i,
    input  logic                           smp_vld_i,
    input  logic [SMP_W-1:0]               smp_i,
    input  logic [N_UNITS-1:0]             unit_en_i,
    input  logic                           both_req_i,
    input  logic [N_UNITS-1:0][SMP_W-1:0]  u_flags_i,
    input  logic [N_UNITS-1:0][SMP_W-1:0]  u_rng_lo_i,
    input  logic [N_UNITS-1:0][SMP_W-1:0]  u_rng_hi_i,
    input  logic [N_UNITS-1:0][SMP_W-1:0]  u_tm_lo_i,
    input  logic [N_UNITS-1:0][SMP_W-1:0]  u_tm_hi_i,
    input  logic [N_UNITS-1:0][SMP_W-1:0]  u_rng_mask_i,
    input  logic [N_UNITS-1:0][SMP_W-1:0]  u_pat_mask_i,
    input  logic [N_UNITS-1:0][SMP_W-1:0]  u_pat_val_i,
    output logic                           trig_o
);
    logic                armed_q;
    logic                trig_q;
    logic                adv;
    logic                fire;
    logic [N_UNITS-1:0]  unit_hit;

    assign adv = smp_vld_i && armed_q && !arm_i;

    for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
        unit_par_t par;
        assign par.rng_lo   = u_rng_lo_i[g];
        assign par.rng_hi   = u_rng_hi_i[g];
        assign par.tm_lo    = u_tm_lo_i[g];
        assign par.tm_hi    = u_tm_hi_i[g];
        assign par.rng_mask = u_rng_mask_i[g];
        assign par.pat_mask = u_pat_mask_i[g];
        assign par.pat_val  = u_pat_val_i[g];

        trig_unit #(.RUN_W(RUN_W)) u_unit (
            .clk    (clk),
            .rst    (rst),
            .clr_i  (arm_i),
            .adv_i  (adv),
            .smp_i  (smp_i),
            .flags_i(unit_flags_t'(u_flags_i[g])),
            .par_i  (par),
            .hit_o  (unit_hit[g])
        );
    end

    always_comb begin
        if (unit_en_i == '0)  fire = 1'b1;
        else if (both_req_i)  fire = &(~unit_en_i | unit_hit);
        else                  fire = |(unit_en_i & unit_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            trig_q  <= 1'b0;
        end else begin
            trig_q  <= adv && fire;
            armed_q <= arm_i || (armed_q && !(adv && fire));
        end
    end

    assign trig_o = trig_q;
endmodule

// File: rtl/trig_chk.sv
`timescale 1ns/1ps
module trig_chk
    import trig_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               arm_i,
    input logic               smp_vld_i,
    input logic               armed,
    input logic [N_UNITS-1:0] unit_en_i,
    input logic               trig_o
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst)         seen_q <= 1'b0;
        else if (arm_i)  seen_q <= 1'b0;
        else if (trig_o) seen_q <= 1'b1;
    end

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

    // R2
    arm_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> !trig_o);

    // R2
    needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> $past(smp_vld_i));

    // R2
    once_per_arm_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> !trig_o);

    // R10
    no_unit_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && smp_vld_i && !arm_i && unit_en_i == '0) |=> trig_o);
endmodule

bind dual_trigger trig_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (arm_i),
    .smp_vld_i(smp_vld_i),
    .armed    (armed_q),
    .unit_en_i(unit_en_i),
    .trig_o   (trig_o)
);

// File: tb/sim_dual_trigger.sv
`timescale 1ns/1ps
module sim_dual_trigger;
    localparam int RUN_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm_r = 1'b0;
    logic vld = 1'b0;
    logic [31:0] smp = '0;
    logic [1:0] uen = '0;
    logic both = 1'b0;
    logic [1:0][31:0] fl, rlo, rhi, tlo, thi, rmsk, pmsk, pval;
    logic trig;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dual_trigger #(.RUN_W(RUN_W)) u0 (
        .clk(clk), .rst(rst), .arm_i(arm_r), .smp_vld_i(vld), .smp_i(smp),
        .unit_en_i(uen), .both_req_i(both),
        .u_flags_i(fl), .u_rng_lo_i(rlo), .u_rng_hi_i(rhi),
        .u_tm_lo_i(tlo), .u_tm_hi_i(thi), .u_rng_mask_i(rmsk),
        .u_pat_mask_i(pmsk), .u_pat_val_i(pval), .trig_o(trig)
    );

    function automatic logic [31:0] ref_pack(input logic [31:0] v, input logic [31:0] m);
        logic [31:0] r;
        int k;
        r = '0;
        k = 0;
        for (int i = 0; i < 32; i++) begin
            if (m[i]) begin
                r[k] = v[i];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic ref_win(input int m, input longint v, input longint lo, input longint hi);
        if (m == 0) return v == hi;
        if (m == 1) return (v == lo) || (v == hi);
        if (m == 2) return (v < lo) || (v > hi);
        return (v > lo) && (v < hi);
    endfunction

    function automatic logic [31:0] mkflags(input int ch, input int edg, input int wm, input int dm,
                                            input int wen, input int den, input int pp, input int pen);
        return 32'(ch) | (32'(edg) << 5) | (32'(wm) << 8) | (32'(dm) << 10) |
               (32'(wen) << 12) | (32'(den) << 13) | (32'(pp) << 16) | (32'(pen) << 18);
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
        end
    endtask

    task automatic cfg_clear();
        fl = {2{32'h0000_0060}};
        rlo = '0; rhi = '0; tlo = '0; thi = '0;
        rmsk = '0; pmsk = '0; pval = '0;
        uen = '0; both = 1'b0;
    endtask

    task automatic do_arm();
        arm_r = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arm_r = 1'b0;
    endtask

    task automatic step(input logic [31:0] s, input logic exp, input string tag);
        vld = 1'b1;
        smp = s;
        @(posedge clk);
        @(negedge clk);
        vld = 1'b0;
        check(trig, exp, tag);
    endtask

    initial begin
        #1_200_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cfg_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, then samples before any arm
        check(trig, 1'b0, "R1 reset");
        step(32'h0, 1'b0, "R1 unarmed");
        step(32'h1, 1'b0, "R1 unarmed");

        // R2: arm and sample in the same cycle
        arm_r = 1'b1; vld = 1'b1; smp = '0;
        @(posedge clk); @(negedge clk);
        arm_r = 1'b0; vld = 1'b0;
        check(trig, 1'b0, "R2 arm-cycle sample ignored");
        step(32'h0, 1'b1, "R10 no unit enabled fires");
        @(posedge clk); @(negedge clk);
        check(trig, 1'b0, "R2 single-cycle pulse");
        step(32'h0, 1'b0, "R2 once per arm");

        // R9: enabled unit with no terms
        uen = 2'b01;
        do_arm();
        step(32'h1234, 1'b1, "R9 no terms");

        // R4: packing sweep through the bus window, relation 00
        for (int i = 0; i < 24; i++) begin
            logic [31:0] d, m;
            d = 32'(i) * 32'h9E37_79B9 ^ 32'h5A5A_0F0F;
            m = 32'(i + 1) * 32'h7F4A_7C15 + 32'(i);
            cfg_clear();
            uen = 2'b01;
            fl[0] = mkflags(0, 3, 0, 0, 1, 0, 0, 0);
            rmsk[0] = m;
            rhi[0] = ref_pack(d, m);
            do_arm();
            step(d, 1'b1, "R4 pack match");
            rhi[0] = ref_pack(d, m) ^ 32'h1;
            do_arm();
            step(d, 1'b0, "R4 pack mismatch");
        end

        // R5: window relations over every 4-bit value
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 16; v++) begin
                cfg_clear();
                uen = 2'b01;
                fl[0] = mkflags(0, 3, m, 0, 1, 0, 0, 0);
                rmsk[0] = 32'h0000_0F00;
                rlo[0] = 32'd5;
                rhi[0] = 32'd9;
                do_arm();
                step(32'(v) << 8 | 32'h0000_F0FF, ref_win(m, v, 5, 9), "R5 window");
            end
        end

        // R3: edge selection per channel
        for (int c = 0; c < 4; c++) begin
            for (int e = 0; e < 4; e++) begin
                int ch, fire_at;
                logic [31:0] s0, s1, s2;
                ch = (c == 0) ? 0 : (c == 1) ? 5 : (c == 2) ? 13 : 31;
                fire_at = (e == 0) ? 1 : (e == 1) ? 2 : (e == 2) ? 1 : 0;
                s0 = 32'hA5A5_A5A5 & ~(32'h1 << ch);
                s1 = s0 | (32'h1 << ch);
                s2 = (s0 ^ 32'hFFFF_0000) & ~(32'h1 << ch);
                cfg_clear();
                uen = 2'b01;
                fl[0] = mkflags(ch, e, 0, 0, 0, 0, 0, 0);
                do_arm();
                step(s0, fire_at == 0, "R3 edge first sample");
                step(s1, fire_at == 1, "R3 edge");
                step(s2, fire_at == 2, "R3 edge");
            end
        end

        // R6: duration relations over run lengths
        for (int m = 0; m < 4; m++) begin
            for (int k = 1; k <= 6; k++) begin
                cfg_clear();
                uen = 2'b01;
                fl[0] = mkflags(0, 3, 0, m, k % 2, 1, 0, 0);
                rmsk[0] = 32'hF;
                rhi[0] = 32'd3;
                tlo[0] = 32'd2;
                thi[0] = 32'd4;
                do_arm();
                for (int j = 0; j < k; j++) step(32'h3, 1'b0, "R6 run in progress");
                step(32'h0, ref_win(m, k, 2, 4), "R6 run end");
                step(32'h0, 1'b0, "R6 after end");
            end
        end

        // R7: saturation of the run counter
        for (int t = 0; t < 3; t++) begin
            int k, lim;
            k = (t == 2) ? 15 : 20;
            lim = (t == 1) ? 4 : 15;
            cfg_clear();
            uen = 2'b01;
            fl[0] = mkflags(0, 3, 0, 0, 0, 1, 0, 0);
            rmsk[0] = 32'hF;
            rhi[0] = 32'd3;
            thi[0] = 32'(lim);
            do_arm();
            for (int j = 0; j < k; j++) step(32'h3, 1'b0, "R7 long run");
            step(32'h0, lim == 15, "R7 saturated length");
        end

        // R8: pattern position against a rising edge on channel 0
        for (int p = 0; p < 4; p++) begin
            for (int q = 0; q < 3; q++) begin
                int fire_at;
                fire_at = (p == 0 && q == 2) ? 2 : (p == 1 && q == 1) ? 1 :
                          (p == 2 && q == 0) ? 1 : -1;
                cfg_clear();
                uen = 2'b01;
                fl[0] = mkflags(0, 0, 0, 0, 0, 0, p, 1);
                pmsk[0] = 32'h0000_00F0;
                pval[0] = 32'hA;
                do_arm();
                for (int j = 0; j < 3; j++) begin
                    step(((j == 1) ? 32'h1 : 32'h0) | ((j == q) ? 32'hA0 : 32'h0),
                         fire_at == j, "R8 pattern position");
                end
            end
        end
        cfg_clear();
        uen = 2'b01;
        fl[0] = mkflags(0, 3, 0, 0, 0, 0, 1, 1);
        pmsk[0] = 32'h0000_00F0;
        pval[0] = 32'hA;
        do_arm();
        step(32'h0000_0057, 1'b0, "R8 pattern only miss");
        step(32'h0000_00A7, 1'b1, "R8 pattern only hit");

        // R10: AND/OR combination with staggered and coinciding edges
        for (int en = 0; en < 4; en++) begin
            for (int a = 0; a < 2; a++) begin
                int fire_at;
                logic [31:0] seq [4];
                seq[0] = 32'h0; seq[1] = 32'h1; seq[2] = 32'h0; seq[3] = 32'h3;
                if (en == 0)      fire_at = 0;
                else if (en == 1) fire_at = 1;
                else if (en == 2) fire_at = 3;
                else              fire_at = (a == 1) ? 3 : 1;
                cfg_clear();
                uen = 2'(en);
                both = a[0];
                fl[0] = mkflags(0, 0, 0, 0, 0, 0, 0, 0);
                fl[1] = mkflags(1, 0, 0, 0, 0, 0, 0, 0);
                do_arm();
                for (int j = 0; j < 4; j++) step(seq[j], fire_at == j, "R10 combine");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule